// File: doc/BRIEF.md
# Serial Port Host Register Bank

This block is the processor-side register file of a classic byte-oriented serial port. A host reaches eight byte-wide registers through a 3-bit address with separate read and write strobes. Read data is combinational from the current state. Any side effect of a read or a write takes place at the clock edge that ends the access.

Transmit bytes are handed to an external bit shifter through a valid/done handshake, with one byte in flight at a time. Received bytes and line-break events come in from an external receiver, which is told through a ready pin whether the buffer is free. A prioritised interrupt identification code drives the single interrupt pin. A loopback option lets the host read its own modem-control outputs back as modem status. Shifting, baud timing, FIFOs and parity are handled elsewhere.

Top module: `uart_regbank`

## Requirements
- R1: When control register (offset 3) bit 7 is set, offsets 0 and 1 read and write the low and high bytes of a 16-bit divisor, and a write to offset 0 starts no transmission.
- R2: With control bit 7 clear, offset 1 reads and writes the interrupt-enable byte: bit 0 enables the receive interrupt and bit 1 enables the transmit interrupt.
- R3: With control bit 7 clear, a write to offset 0 raises `tx_valid` with the byte on `tx_data`, clears status (offset 5) bits 5 and 6, and clears the hidden transmit-pending flag. `tx_valid` holds until `tx_done`. At that edge `tx_valid` falls, status bits 5 and 6 are set and transmit-pending is set.
- R4: A transmit write while `tx_valid` is high replaces `tx_data`. A write in the same cycle as `tx_done` wins, so `tx_valid` stays high and the empty bits stay clear.
- R5: A read of offset 0 with control bit 7 clear returns the receive buffer and clears status bit 0 (data ready) and bit 4 (break).
- R6: A received byte loads the buffer and sets data ready, and `rx_ready` is the inverse of data ready. A byte arriving in the same cycle as a buffer read is kept, and data ready stays set.
- R7: A byte or break arriving while data ready is set raises status bit 1 (overrun). A read of offset 5 clears bit 1 unless another such arrival happens in the same cycle.
- R8: A break event loads 0x00 into the buffer and sets status bits 4 and 0.
- R9: Offset 2 reads 0x04 when data ready is set and the receive interrupt is enabled. Otherwise it reads 0x02 when transmit-pending is set and the transmit interrupt is enabled. Otherwise it reads 0x01.
- R10: `irq` is high exactly when the identification code is not 0x01.
- R11: A read of offset 2 that returns 0x02 clears transmit-pending. A read that returns 0x04 leaves it set.
- R12: When modem control (offset 4) bit 4 is set, offset 6 reads modem control bits 3:2 on bits 7:6, bit 0 on bit 5 and bit 1 on bit 4, with the other bits zero. Otherwise offset 6 reads the byte last written there.
- R13: Writes to offsets 2 and 5 change nothing. Offsets 3, 4 and 7 read back the last byte written.
- R14: After reset, status reads 0x60, identification reads 0x01, `irq` and `tx_valid` are low and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe (enables read side effects) |
| bus_rdata | output | DATA_W | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Byte waiting for the shifter |
| tx_data | output | DATA_W | Byte to transmit |
| tx_done | input | 1 | Shifter has taken the byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | DATA_W | Received byte |
| rx_break | input | 1 | Line-break event strobe |
| rx_ready | output | 1 | Receive buffer free |

## Verification
The collisions that matter are a host access and a line-side event falling on the same edge. The bench provokes these by raising the host strobe and the line-side strobe together. A transmit write is issued in the cycle the shifter reports done, and the bench requires `tx_valid` to stay high with the new byte and the empty bits clear. A received byte is delivered in the same cycle as a buffer read. The bench expects the read to return the old byte, the new byte to remain readable afterwards, and overrun to be flagged. Identification reads made while a receive interrupt masks a pending transmit interrupt show that only a read returning 0x02 clears the hidden flag.

// File: rtl/uart_rb_pkg.sv
`timescale 1ns/1ps
package uart_rb_pkg;
   // register offsets (low three address bits)
   typedef enum logic [2:0] {
      OFS_DATA  = 3'd0,
      OFS_ENA   = 3'd1,
      OFS_IDENT = 3'd2,
      OFS_CTRL  = 3'd3,
      OFS_MCTL  = 3'd4,
      OFS_STAT  = 3'd5,
      OFS_MSTAT = 3'd6,
      OFS_SCR   = 3'd7
   } reg_ofs_e;

   localparam logic [7:0] IID_NONE = 8'h01;
   localparam logic [7:0] IID_TX   = 8'h02;
   localparam logic [7:0] IID_RX   = 8'h04;

   localparam int ENA_RX_BIT = 0;
   localparam int ENA_TX_BIT = 1;
endpackage

// File: rtl/uart_rb_tx.sv
`timescale 1ns/1ps
module uart_rb_tx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              done,
   input  logic              pend_clr,
   output logic              valid,
   output logic [DATA_W-1:0] data,
   output logic              hold_empty,
   output logic              line_empty,
   output logic              pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid      <= 1'b0;
         data       <= '0;
         hold_empty <= 1'b1;
         line_empty <= 1'b1;
         pend       <= 1'b0;
      end else if (load) begin
         // a new write always wins, even against a simultaneous done
         valid      <= 1'b1;
         data       <= load_data;
         hold_empty <= 1'b0;
         line_empty <= 1'b0;
         pend       <= 1'b0;
      end else if (valid && done) begin
         valid      <= 1'b0;
         hold_empty <= 1'b1;
         line_empty <= 1'b1;
         pend       <= 1'b1;
      end else if (pend_clr) begin
         pend <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_rb_rx.sv
`timescale 1ns/1ps
module uart_rb_rx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_byte,
   input  logic              in_break,
   input  logic              buf_rd,
   input  logic              stat_rd,
   output logic [DATA_W-1:0] buf_q,
   output logic              ready_q,
   output logic              brk_q,
   output logic              ovr_q
);
   logic arrive;
   assign arrive = in_valid || in_break;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q   <= '0;
         ready_q <= 1'b0;
         brk_q   <= 1'b0;
      end else if (in_break) begin
         buf_q   <= '0;
         ready_q <= 1'b1;
         brk_q   <= 1'b1;
      end else if (in_valid) begin
         buf_q   <= in_byte;
         ready_q <= 1'b1;
      end else if (buf_rd) begin
         ready_q <= 1'b0;
         brk_q   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ovr_q <= 1'b0;
      else if (arrive && ready_q) ovr_q <= 1'b1;
      else if (stat_rd)           ovr_q <= 1'b0;
   end
endmodule

// File: rtl/uart_rb_ident.sv
`timescale 1ns/1ps
module uart_rb_ident
   import uart_rb_pkg::*;
(
   input  logic       data_rdy,
   input  logic       tx_pend,
   input  logic       ena_rx,
   input  logic       ena_tx,
   output logic [7:0] code,
   output logic       irq
);
   always_comb begin
      if (data_rdy && ena_rx)     code = IID_RX;
      else if (tx_pend && ena_tx) code = IID_TX;
      else                        code = IID_NONE;
   end
   assign irq = (code != IID_NONE);
endmodule

// File: rtl/uart_regbank.sv
`timescale 1ns/1ps
module uart_regbank
   import uart_rb_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 8,
   parameter int LATCH_BIT   = 7,
   parameter int LOOP_BIT    = 4,
   parameter bit LOOPBACK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_done,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_break,
   output logic              rx_ready
);
   localparam int DIV_W = 2 * DATA_W;

   if (DATA_W != 8) begin : g_bad_width
      $error("uart_regbank: registers are byte wide, DATA_W must be 8");
   end
   if (ADDR_W != 3) begin : g_bad_addr
      $error("uart_regbank: eight registers need ADDR_W of 3");
   end
   if (LATCH_BIT >= DATA_W || LOOP_BIT >= DATA_W) begin : g_bad_bit
      $error("uart_regbank: control bit positions out of range");
   end

   reg_ofs_e          ofs;
   logic [DATA_W-1:0] ctrl_q, mctl_q, ena_q, mstat_q, scr_q, mstat_view;
   logic [DIV_W-1:0]  div_q;
   logic              latch_sel;
   logic              tx_load, buf_rd, stat_rd, pend_clr;
   logic              thre_w, temt_w, pend_w;
   logic [DATA_W-1:0] rbr_w;
   logic              dr_w, bi_w, oe_w;
   logic [7:0]        iid_w;
   logic [DATA_W-1:0] stat_view;

   assign ofs       = reg_ofs_e'(bus_addr[2:0]);
   assign latch_sel = ctrl_q[LATCH_BIT];

   // access decode
   assign tx_load  = bus_wr && (ofs == OFS_DATA) && !latch_sel;
   assign buf_rd   = bus_rd && (ofs == OFS_DATA) && !latch_sel;
   assign stat_rd  = bus_rd && (ofs == OFS_STAT);
   assign pend_clr = bus_rd && (ofs == OFS_IDENT) && (iid_w == IID_TX);

   // plain storage registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         mctl_q  <= '0;
         ena_q   <= '0;
         mstat_q <= '0;
         scr_q   <= '0;
         div_q   <= '0;
      end else if (bus_wr) begin
         unique case (ofs)
            OFS_DATA:  if (latch_sel) div_q[DATA_W-1:0] <= bus_wdata;
            OFS_ENA:   if (latch_sel) div_q[DIV_W-1:DATA_W] <= bus_wdata;
                       else           ena_q <= bus_wdata;
            OFS_CTRL:  ctrl_q  <= bus_wdata;
            OFS_MCTL:  mctl_q  <= bus_wdata;
            OFS_MSTAT: mstat_q <= bus_wdata;
            OFS_SCR:   scr_q   <= bus_wdata;
            default:   ; // identification and status are read-only
         endcase
      end
   end

   uart_rb_tx #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .load(tx_load), .load_data(bus_wdata), .done(tx_done),
      .pend_clr(pend_clr),
      .valid(tx_valid), .data(tx_data),
      .hold_empty(thre_w), .line_empty(temt_w), .pend(pend_w)
   );

   uart_rb_rx #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .in_valid(rx_valid), .in_byte(rx_byte), .in_break(rx_break),
      .buf_rd(buf_rd), .stat_rd(stat_rd),
      .buf_q(rbr_w), .ready_q(dr_w), .brk_q(bi_w), .ovr_q(oe_w)
   );

   uart_rb_ident u_ident (
      .data_rdy(dr_w), .tx_pend(pend_w),
      .ena_rx(ena_q[ENA_RX_BIT]), .ena_tx(ena_q[ENA_TX_BIT]),
      .code(iid_w), .irq(irq)
   );

   assign rx_ready  = !dr_w;
   assign stat_view = {1'b0, temt_w, thre_w, bi_w, 2'b00, oe_w, dr_w};

   // modem status view: loopback variant or plain register
   if (LOOPBACK_EN) begin : g_loop
      always_comb begin
         if (mctl_q[LOOP_BIT])
            mstat_view = {mctl_q[3:2], mctl_q[0], mctl_q[1], 4'b0000};
         else
            mstat_view = mstat_q;
      end
   end else begin : g_noloop
      assign mstat_view = mstat_q;
   end

   // read mux
   always_comb begin
      unique case (ofs)
         OFS_DATA:  bus_rdata = latch_sel ? div_q[DATA_W-1:0] : rbr_w;
         OFS_ENA:   bus_rdata = latch_sel ? div_q[DIV_W-1:DATA_W] : ena_q;
         OFS_IDENT: bus_rdata = iid_w;
         OFS_CTRL:  bus_rdata = ctrl_q;
         OFS_MCTL:  bus_rdata = mctl_q;
         OFS_STAT:  bus_rdata = stat_view;
         OFS_MSTAT: bus_rdata = mstat_view;
         default:   bus_rdata = scr_q;
      endcase
   end
endmodule

// File: rtl/uart_regbank_chk.sv
`timescale 1ns/1ps
module uart_regbank_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_load,
   input logic              tx_valid,
   input logic              tx_done,
   input logic              thre,
   input logic              rx_valid,
   input logic              rx_break,
   input logic              rx_ready,
   input logic [DATA_W-1:0] rbr,
   input logic              dr,
   input logic              bi,
   input logic              pend,
   input logic [DATA_W-1:0] ena,
   input logic [7:0]        iid,
   input logic              pend_clr,
   input logic              irq
);
   p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_done) |=> tx_valid);

   p_tx_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_done && !tx_load) |=> (!tx_valid && thre && pend));

   p_write_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> (tx_valid && !thre));

   p_rx_arrival_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_ready);

   p_break_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_break |=> (bi && dr && rbr == '0));

   p_rx_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dr && ena[0]) |-> (iid == 8'h04));

   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!dr && !(pend && ena[1])) |-> !irq);

   p_ident_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_clr && !tx_load && !(tx_valid && tx_done)) |=> !pend);
endmodule

bind uart_regbank uart_regbank_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .tx_load(tx_load), .tx_valid(tx_valid), .tx_done(tx_done), .thre(thre_w),
   .rx_valid(rx_valid), .rx_break(rx_break), .rx_ready(rx_ready),
   .rbr(rbr_w), .dr(dr_w), .bi(bi_w), .pend(pend_w), .ena(ena_q),
   .iid(iid_w), .pend_clr(pend_clr), .irq(irq)
);

// File: tb/sim_uart_regbank.sv
`timescale 1ns/1ps
module sim_uart_regbank;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic       irq, tx_valid, rx_ready;
   logic [7:0] tx_data;
   logic       tx_done = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       rx_break = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   uart_regbank u0 (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_done(tx_done),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
      .rx_ready(rx_ready)
   );

   function automatic void chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endfunction

   // monitor: compare read data against queued expectations mid-cycle
   always @(negedge clk) begin
      if (bus_rd) begin
         if (exp_q.size() == 0) begin
            chk("monitor underflow", 8'h00, 8'hff);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(t, bus_rdata, e);
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1 bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
      exp_q.push_back(e); tag_q.push_back(t);
      bus_addr = a; bus_rd = 1'b1;
      @(posedge clk); #1 bus_rd = 1'b0;
   endtask

   task automatic rx(input logic [7:0] b);
      rx_byte = b; rx_valid = 1'b1;
      @(posedge clk); #1 rx_valid = 1'b0;
   endtask

   task automatic done_pulse();
      tx_done = 1'b1;
      @(posedge clk); #1 tx_done = 1'b0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R14 reset state
      chk("R14 irq", {7'b0, irq}, 8'h00);
      chk("R14 tx_valid", {7'b0, tx_valid}, 8'h00);
      chk("R14 rx_ready", {7'b0, rx_ready}, 8'h01);
      rd(3'd5, 8'h60, "R14 status");
      rd(3'd2, 8'h01, "R14 ident");

      // R13 plain registers and ignored writes
      wr(3'd7, 8'hA5); rd(3'd7, 8'hA5, "R13 scratch");
      wr(3'd4, 8'h03); rd(3'd4, 8'h03, "R13 modem ctrl");
      wr(3'd2, 8'hFF); rd(3'd2, 8'h01, "R13 ident write ignored");
      wr(3'd5, 8'h00); rd(3'd5, 8'h60, "R13 status write ignored");
      wr(3'd4, 8'h00);

      // R1 divisor latch
      wr(3'd3, 8'h80); rd(3'd3, 8'h80, "R13 ctrl");
      wr(3'd0, 8'h34);
      wr(3'd1, 8'h12);
      chk("R1 no transmit", {7'b0, tx_valid}, 8'h00);
      rd(3'd0, 8'h34, "R1 divisor low");
      rd(3'd1, 8'h12, "R1 divisor high");
      wr(3'd3, 8'h03);
      rd(3'd1, 8'h00, "R1 enable untouched");

      // R2 interrupt enable
      wr(3'd1, 8'h03); rd(3'd1, 8'h03, "R2 enable");
      chk("R10 idle irq", {7'b0, irq}, 8'h00);

      // R3 transmit handoff
      wr(3'd0, 8'h41);
      chk("R3 valid", {7'b0, tx_valid}, 8'h01);
      chk("R3 data", tx_data, 8'h41);
      rd(3'd5, 8'h00, "R3 empty bits clear");
      repeat (3) @(posedge clk); #1;
      chk("R3 hold", {7'b0, tx_valid}, 8'h01);
      wr(3'd0, 8'h42);
      chk("R4 replace", tx_data, 8'h42);
      done_pulse();
      chk("R3 release", {7'b0, tx_valid}, 8'h00);
      rd(3'd5, 8'h60, "R3 empty bits set");
      chk("R10 tx irq", {7'b0, irq}, 8'h01);
      rd(3'd2, 8'h02, "R9 tx code");
      chk("R11 cleared irq", {7'b0, irq}, 8'h00);
      rd(3'd2, 8'h01, "R11 code after clear");

      // R4 write in the same cycle as done
      wr(3'd0, 8'h50);
      bus_addr = 3'd0; bus_wdata = 8'h51; bus_wr = 1'b1; tx_done = 1'b1;
      @(posedge clk); #1 bus_wr = 1'b0; tx_done = 1'b0;
      chk("R4 collide valid", {7'b0, tx_valid}, 8'h01);
      chk("R4 collide data", tx_data, 8'h51);
      rd(3'd5, 8'h00, "R4 collide status");
      done_pulse();
      chk("R3 pending irq", {7'b0, irq}, 8'h01);

      // R9/R11 receive priority over transmit
      rx(8'h77);
      chk("R6 ready low", {7'b0, rx_ready}, 8'h00);
      rd(3'd2, 8'h04, "R9 rx code");
      rd(3'd0, 8'h77, "R5 buffer");
      chk("R5 ready back", {7'b0, rx_ready}, 8'h01);
      rd(3'd2, 8'h02, "R11 pending kept");
      rd(3'd2, 8'h01, "R11 pending cleared");
      chk("R10 irq low", {7'b0, irq}, 8'h00);

      // R7 overrun
      rx(8'h10); rx(8'h20);
      rd(3'd5, 8'h63, "R7 overrun set");
      rd(3'd5, 8'h61, "R7 overrun cleared");
      rd(3'd0, 8'h20, "R7 newest kept");
      rd(3'd5, 8'h60, "R5 ready cleared");

      // R6 arrival in the same cycle as buffer read
      rx(8'h11);
      exp_q.push_back(8'h11); tag_q.push_back("R6 old byte");
      bus_addr = 3'd0; bus_rd = 1'b1; rx_byte = 8'h22; rx_valid = 1'b1;
      @(posedge clk); #1 bus_rd = 1'b0; rx_valid = 1'b0;
      chk("R6 ready after collide", {7'b0, rx_ready}, 8'h00);
      rd(3'd5, 8'h63, "R6 collide status");
      rd(3'd0, 8'h22, "R6 new byte kept");
      rd(3'd5, 8'h60, "R6 status after");

      // R8 break
      rx_break = 1'b1; @(posedge clk); #1 rx_break = 1'b0;
      chk("R8 ready", {7'b0, rx_ready}, 8'h00);
      rd(3'd5, 8'h71, "R8 status");
      rd(3'd0, 8'h00, "R8 buffer zero");
      rd(3'd5, 8'h60, "R5 break cleared");

      // R12 loopback
      wr(3'd6, 8'h5A); rd(3'd6, 8'h5A, "R12 plain");
      wr(3'd4, 8'h1D); rd(3'd6, 8'hE0, "R12 loop 1D");
      wr(3'd4, 8'h12); rd(3'd6, 8'h10, "R12 loop 12");
      wr(3'd4, 8'h00); rd(3'd6, 8'h5A, "R12 loop off");

      // R10 masked receive interrupt
      wr(3'd1, 8'h00);
      rx(8'h33);
      chk("R10 masked", {7'b0, irq}, 8'h00);
      rd(3'd2, 8'h01, "R9 masked code");
      wr(3'd1, 8'h01);
      chk("R10 unmasked", {7'b0, irq}, 8'h01);
      rd(3'd0, 8'h33, "R5 last byte");
      chk("R10 drop", {7'b0, irq}, 8'h00);

      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule